// File: doc/BRIEF.md
# Triggered Sample-and-Hold Register

This block holds a vector of `LANES` signed samples, each `WIDTH` bits wide. A one-bit trigger is sampled on every clock, at the same rate as the data. When the selected kind of trigger edge occurs, the block copies the data vector into its output register. The output then keeps that value until the next qualifying edge.

A two-bit run-time select sets which edges count as events. Before the first event, the output shows an initial value. That value is taken during reset from an initial-value bus. It is either one scalar copied to every lane or a separate value for each lane.

An optional latch mode changes what is stored: a trigger stores the data input from the clock before the trigger instead of the present one. The stored value therefore never depends on the data of the same cycle, and the block can sit inside a feedback loop. A one-cycle valid pulse marks each new capture. A sticky flag tells whether any event has been seen since reset.

Top module: `trig_sample_hold`

## Requirements
- R1: With `trigMode` = 2'b00, a trigger rise counts as an event. A rise is 0 on the previous clock and 1 on this clock. A fall or a steady trigger does not count.
- R2: With `trigMode` = 2'b01, only a trigger fall counts as an event. A fall is 1 on the previous clock and 0 on this clock.
- R3: With `trigMode` = 2'b10, both rises and falls count as events. The code 2'b11 behaves exactly like 2'b00.
- R4: When latch mode is off, an event detected at clock edge k loads `dataIn` as sampled at edge k into `dataOut`. The new value is visible right after edge k.
- R5: When no event occurs at an edge, `dataOut` keeps its previous value.
- R6: When `latchMode` = 1, an event at edge k loads the `dataIn` value sampled at edge k-1.
- R7: Synchronous active-high reset has these effects:
  - `dataOut` takes the initial value.
  - `outValid` and `everTriggered` go low.
  - The remembered previous trigger becomes 0, so a trigger held high through the release of reset is a rise on the first clock after release.
- R8: When `initPerLane` = 1, lane i of `dataOut` takes bits [i*WIDTH +: WIDTH] of `initBus` during reset. When `initPerLane` = 0, every lane takes bits [WIDTH-1:0].
- R9: `everTriggered` rises together with the first capture after reset. It stays high until the next reset.
- R10: `outValid` is high for exactly the one cycle after each edge where an event was detected. A trigger held steady produces no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigIn | input | 1 | Scalar trigger, sampled each clock |
| trigMode | input | 2 | Event select: 00 rise, 01 fall, 10 both edges, 11 rise |
| latchMode | input | 1 | 1 = capture the previous clock's data |
| initPerLane | input | 1 | 1 = separate initial value per lane, 0 = lane 0 value copied to all lanes |
| initBus | input | LANES*WIDTH | Initial values, sampled during reset |
| dataIn | input | LANES*WIDTH | Data vector, lane i at [i*WIDTH +: WIDTH] |
| dataOut | output | LANES*WIDTH | Held output vector |
| outValid | output | 1 | One-cycle pulse after each capture |
| everTriggered | output | 1 | High once any event has been seen since reset |

## Verification
The hardest situations to reach are at the edges of reset. One is a trigger held high through the release of reset, which must count as a rise. The other is a latch-mode capture on the first clock after release, which must store data that was applied while reset was still asserted. Directed sequences set up both. Random stimulus follows with trigger toggles of varying density, mode and latch changes at arbitrary times, and occasional resets with fresh initial buses in both scalar and per-lane form. This exercises every select code against single-cycle and long trigger pulses.

// File: rtl/sh_pkg.sv
package sh_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_ALT  = 2'b11
  } edgeSel_t;

  typedef struct packed {
    logic load;        // capture this clock
    logic useDelayed;  // take the one-clock-old data
  } holdCtl_t;

endpackage

// File: rtl/sh_trigger_ctrl.sv
module sh_trigger_ctrl
  import sh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trigIn,
  input  logic [1:0] trigMode,
  input  logic       latchMode,
  output holdCtl_t   ctl,
  output logic       validPulse,
  output logic       seenFlag
);

  logic     trigPrev;
  logic     riseHit;
  logic     fallHit;
  logic     eventHit;
  edgeSel_t sel;

  assign sel     = edgeSel_t'(trigMode);
  assign riseHit = trigIn & ~trigPrev;
  assign fallHit = ~trigIn & trigPrev;

  always_comb begin
    unique case (sel)
      EDGE_FALL: eventHit = fallHit;
      EDGE_BOTH: eventHit = riseHit | fallHit;
      default:   eventHit = riseHit;
    endcase
  end

  always_comb begin
    ctl.load       = eventHit & ~rst;
    ctl.useDelayed = latchMode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigPrev   <= 1'b0;
      validPulse <= 1'b0;
      seenFlag   <= 1'b0;
    end else begin
      trigPrev   <= trigIn;
      validPulse <= eventHit;
      if (eventHit) seenFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/sh_datapath.sv
module sh_datapath
  import sh_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  holdCtl_t               ctl,
  input  logic                   initPerLane,
  input  logic [LANES*WIDTH-1:0] initBus,
  input  logic [LANES*WIDTH-1:0] dataIn,
  output logic [LANES*WIDTH-1:0] dataOut
);

  localparam int BUS_W = LANES * WIDTH;

  logic [BUS_W-1:0] dataPrev;
  logic [BUS_W-1:0] initVec;
  logic [BUS_W-1:0] capSrc;

  // one-clock-old copy of the input, free running
  always_ff @(posedge clk) dataPrev <= dataIn;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic signed [WIDTH-1:0] laneInit;
    logic signed [WIDTH-1:0] laneSrc;
    logic signed [WIDTH-1:0] laneHold;

    assign laneInit = initPerLane ? initBus[ln*WIDTH +: WIDTH] : initBus[WIDTH-1:0];
    assign laneSrc  = ctl.useDelayed ? dataPrev[ln*WIDTH +: WIDTH] : dataIn[ln*WIDTH +: WIDTH];

    always_ff @(posedge clk) begin
      if (rst)           laneHold <= laneInit;
      else if (ctl.load) laneHold <= laneSrc;
    end

    assign initVec[ln*WIDTH +: WIDTH] = laneInit;
    assign capSrc[ln*WIDTH +: WIDTH]  = laneSrc;
    assign dataOut[ln*WIDTH +: WIDTH] = laneHold;
  end

endmodule

// File: rtl/trig_sample_hold.sv
module trig_sample_hold
  import sh_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   trigIn,
  input  logic [1:0]             trigMode,
  input  logic                   latchMode,
  input  logic                   initPerLane,
  input  logic [LANES*WIDTH-1:0] initBus,
  input  logic [LANES*WIDTH-1:0] dataIn,
  output logic [LANES*WIDTH-1:0] dataOut,
  output logic                   outValid,
  output logic                   everTriggered
);

  holdCtl_t ctl;

  sh_trigger_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .trigIn     (trigIn),
    .trigMode   (trigMode),
    .latchMode  (latchMode),
    .ctl        (ctl),
    .validPulse (outValid),
    .seenFlag   (everTriggered)
  );

  sh_datapath #(.LANES(LANES), .WIDTH(WIDTH)) u_path (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .initPerLane (initPerLane),
    .initBus     (initBus),
    .dataIn      (dataIn),
    .dataOut     (dataOut)
  );

endmodule

// File: rtl/trig_sample_hold_checker.sv
module trig_sample_hold_checker #(
  parameter int LANES = 4,
  parameter int WIDTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   trigIn,
  input logic [1:0]             trigMode,
  input logic                   latchMode,
  input logic                   initPerLane,
  input logic [LANES*WIDTH-1:0] initBus,
  input logic [LANES*WIDTH-1:0] dataIn,
  input logic [LANES*WIDTH-1:0] dataOut,
  input logic                   outValid,
  input logic                   everTriggered
);

  assert_rise_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(trigMode) == 2'b00 || $past(trigMode) == 2'b11))
      |-> (outValid == ($past(trigIn) && !$past(trigIn, 2))));

  assert_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(trigMode) == 2'b01)
      |-> (outValid == (!$past(trigIn) && $past(trigIn, 2))));

  assert_both_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(trigMode) == 2'b10)
      |-> (outValid == ($past(trigIn) != $past(trigIn, 2))));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(rst) && !$past(latchMode)) |-> (dataOut == $past(dataIn)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> $stable(dataOut));

  assert_latch_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(rst) && $past(latchMode)) |-> (dataOut == $past(dataIn, 2)));

  assert_reset_R7: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && !everTriggered));

  assert_init_R8: assert property (@(posedge clk)
    ($past(rst) && $past(initPerLane)) |-> (dataOut == $past(initBus)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    outValid |-> everTriggered);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(rst)) |-> $past(trigIn) != $past(trigIn, 2) || $past(rst, 2));

endmodule

bind trig_sample_hold trig_sample_hold_checker #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .trigIn        (trigIn),
  .trigMode      (trigMode),
  .latchMode     (latchMode),
  .initPerLane   (initPerLane),
  .initBus       (initBus),
  .dataIn        (dataIn),
  .dataOut       (dataOut),
  .outValid      (outValid),
  .everTriggered (everTriggered)
);

// File: tb/trig_sample_hold_tb_top.sv
module trig_sample_hold_tb_top;

  localparam int LANES = 4;
  localparam int WIDTH = 16;
  localparam int BUS_W = LANES * WIDTH;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             trigIn = 1'b0;
  logic [1:0]       trigMode = 2'b00;
  logic             latchMode = 1'b0;
  logic             initPerLane = 1'b1;
  logic [BUS_W-1:0] initBus = '0;
  logic [BUS_W-1:0] dataIn = '0;
  logic [BUS_W-1:0] dataOut;
  logic             outValid;
  logic             everTriggered;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  logic [BUS_W-1:0] expOut = '0;
  logic             expValid = 1'b0;
  logic             expSeen = 1'b0;
  logic             mTrigPrev = 1'b0;
  logic [BUS_W-1:0] mDataPrev = '0;
  logic             lastWasReset = 1'b1;
  logic             lastLatch = 1'b0;
  logic [1:0]       lastMode = 2'b00;

  always #10 clk = ~clk;

  trig_sample_hold #(.LANES(LANES), .WIDTH(WIDTH)) dut_i (
    .clk (clk), .rst (rst), .trigIn (trigIn), .trigMode (trigMode),
    .latchMode (latchMode), .initPerLane (initPerLane), .initBus (initBus),
    .dataIn (dataIn), .dataOut (dataOut), .outValid (outValid),
    .everTriggered (everTriggered)
  );

  function automatic logic [BUS_W-1:0] initValue(logic [BUS_W-1:0] bus, logic perLane);
    logic [BUS_W-1:0] v;
    for (int i = 0; i < LANES; i++)
      v[i*WIDTH +: WIDTH] = perLane ? bus[i*WIDTH +: WIDTH] : bus[WIDTH-1:0];
    return v;
  endfunction

  function automatic logic isEvent(logic [1:0] mode, logic cur, logic prev);
    case (mode)
      2'b01:   return !cur && prev;
      2'b10:   return cur != prev;
      default: return cur && !prev;
    endcase
  endfunction

  always @(posedge clk) begin
    lastWasReset = rst;
    lastLatch    = latchMode;
    lastMode     = trigMode;
    if (rst) begin
      expOut    = initValue(initBus, initPerLane);
      expValid  = 1'b0;
      expSeen   = 1'b0;
      mTrigPrev = 1'b0;
    end else begin
      expValid = isEvent(trigMode, trigIn, mTrigPrev);
      if (expValid) begin
        expOut  = latchMode ? mDataPrev : dataIn;
        expSeen = 1'b1;
      end
      mTrigPrev = trigIn;
    end
    mDataPrev = dataIn;
  end

  task automatic check(string req, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare all outputs, tagging by what the last edge exercised
  task automatic checkAll(string extra);
    string dTag;
    string vTag;
    if (lastWasReset) dTag = (extra != "") ? extra : "R7";
    else if (expValid) dTag = lastLatch ? "R6" : "R4";
    else dTag = "R5";
    case (lastMode)
      2'b01:   vTag = "R2";
      2'b10:   vTag = "R3";
      2'b11:   vTag = "R3";
      default: vTag = "R1";
    endcase
    if (!expValid && !lastWasReset && mTrigPrev == trigIn) vTag = "R10";
    check(dTag, dataOut, expOut, "dataOut");
    check(lastWasReset ? "R7" : vTag, {{(BUS_W-1){1'b0}}, outValid},
          {{(BUS_W-1){1'b0}}, expValid}, "outValid");
    check("R9", {{(BUS_W-1){1'b0}}, everTriggered},
          {{(BUS_W-1){1'b0}}, expSeen}, "everTriggered");
  endtask

  task automatic step(string extra = "");
    @(negedge clk);
    checkAll(extra);
  endtask

  function automatic logic [BUS_W-1:0] rndBus();
    logic [BUS_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*WIDTH +: WIDTH] = WIDTH'($urandom);
    return v;
  endfunction

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_1234);
    // R8 scalar init, with trigger held high through reset (R7)
    rst = 1; initPerLane = 0; initBus = rndBus(); trigIn = 1; dataIn = rndBus();
    repeat (3) step("R8");
    rst = 0; dataIn = rndBus();
    step();            // rise right after release
    step();
    // R8 per-lane init, latch capture on first clock after release (R6)
    rst = 1; initPerLane = 1; initBus = rndBus(); trigIn = 0; latchMode = 1;
    dataIn = rndBus();
    repeat (2) step("R8");
    rst = 0; trigIn = 1; dataIn = rndBus();
    step(); step();
    latchMode = 0;
    // directed: each mode with a pulse
    for (int m = 0; m < 4; m++) begin
      trigMode = 2'(m);
      trigIn = 0; dataIn = rndBus(); step();
      trigIn = 1; dataIn = rndBus(); step();
      dataIn = rndBus(); step(); step();   // held high: no extra pulse
      trigIn = 0; dataIn = rndBus(); step();
      step();
    end
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2) begin
        rst = 1; initPerLane = 1'($urandom); initBus = rndBus();
      end else rst = 0;
      if ($urandom_range(0, 19) == 0) trigMode = 2'($urandom);
      if ($urandom_range(0, 29) == 0) latchMode = ~latchMode;
      if ($urandom_range(0, 3) == 0) trigIn = ~trigIn;
      dataIn = rndBus();
      step();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule